// File: doc/BRIEF.md
# Pattern-Instruction Address Sequencer

This block sequences a shared arithmetic datapath that takes one operand from each of two data RAMs (RAM A and RAM B). Either RAM can accept the result. The block holds no per-cycle control words. It holds a short program of pattern instructions. Each instruction expands into a multi-cycle run of addresses:

- a linear run over consecutive words, such as a long chain of additions;
- the full read order of a small matrix-vector product;
- the same product with the matrix read in transposed order.

One pulse on `start` runs the program once for each of several independent problems. When the last instruction of a problem has issued, the program counter returns to instruction 0. Every address generated for problem p is then offset by p times a fixed stride.

The program is split over four single-port ROMs, and all four are addressed by the same program counter:

| ROM | Contents |
|---|---|
| Read-A ROM | pattern kind and operand-A base |
| Read-B ROM | row count and operand-B base |
| Write ROM | destination RAM, column count and write base |
| Op ROM | operation |

A write address travels down a delay line for the latency of its operation, so it appears together with the result. A divide has a longer latency than an add or a multiply. After each divide the block inserts idle slots, so that the next write cannot land before the divide's write.

The built-in program is as follows. The "Write" column gives the write base and the destination RAM.

| # | Kind | A base | B base | Rows | Cols | Write | Op |
|---|---|---|---|---|---|---|---|
| 0 | linear | 0 | 0 | 3 | 1 | 8, RAM A | add |
| 1 | mat-vec | 16 | 4 | 2 | 3 | 12, RAM B | mul |
| 2 | mat-vec transposed | 16 | 20 | 2 | 3 | 24, RAM A | mul |
| 3 | linear | 30 | 31 | 2 | 1 | 40, RAM B | div |

Top module: `pattern_addr_seq`

## Requirements
- R1: After reset, and whenever idle, `busy`, `done`, `op_vld` and `wr_en` are 0 and `op_sel` is 0.
- R2: A linear instruction of length L issues L consecutive slots at step k = 0..L-1. In slot k, `rda_addr` is A base + k and `rdb_addr` is B base + k.
- R3: A mat-vec instruction with r rows and c columns issues r·c slots, row i outer and column j inner. In each slot, `rda_addr` is A base + i·c + j and `rdb_addr` is B base + j.
- R4: A transposed mat-vec instruction issues r·c slots, column j outer and row i inner. In each slot, `rda_addr` is A base + j + i·c and `rdb_addr` is B base + i.
- R5: A write is produced only on the last inner step of each outer index, which is every step for a linear instruction. It carries `wr_addr` = write base + outer index and `wr_sel` (0 selects RAM A, 1 selects RAM B). It appears LAT_ADD cycles after the issue slot for add and multiply, and LAT_DIV cycles after it for divide.
- R6: `op_sel` encodes 1 for add, 2 for multiply, 3 for divide, and 0 when no operation is issued. Every divide slot is followed by exactly LAT_DIV-LAT_ADD idle slots, with `op_vld` 0 and `op_sel` 0.
- R7: Slots are issued back to back in program order. After the last instruction the program restarts at instruction 0 for the next problem. Every read and write address of problem p is increased by p·PROB_STRIDE.
- R8: A `start` pulse while idle raises `busy` on the next cycle, and the first slot issues in that same cycle. `done` pulses for one cycle in the cycle after the final slot, including any trailing idle slots. `busy` falls on the cycle after `done`. A later start begins again at problem 0.
- R9: `start` has no effect while `busy` is high. The slot sequence is unchanged and `done` pulses only once per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run over all problems |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| op_vld | output | 1 | An operation is issued this cycle |
| op_sel | output | 2 | Operation code |
| rda_addr | output | ADDR_W | Read address of RAM A |
| rdb_addr | output | ADDR_W | Read address of RAM B |
| wr_en | output | 1 | Result write strobe |
| wr_sel | output | 1 | Destination RAM of the write |
| wr_addr | output | ADDR_W | Write address |

## Verification
The bench builds the block with its defaults:

- two problems with a stride of 64;
- a latency of 12 for add and multiply and 27 for divide;
- the four-instruction program above.

With these values all three pattern kinds appear in one run. A divide closes the program, so the trailing idle slots must pass before `done`. Its delayed writes overlap the start of the next problem, which brings the wrap with its offset within reach. The bench runs the program twice, and the second run carries a stray `start` in mid-run. This exercises the restart from problem 0 and confirms that a start while busy is ignored.

// File: rtl/pas_pkg.sv
// Package: shared encodings and the built-in pattern program.
// Assumes base fields of 8 bits and dimension fields of 4 bits.
package pas_pkg;

    typedef enum logic [1:0] {OP_NONE = 2'd0, OP_ADD = 2'd1, OP_MUL = 2'd2, OP_DIV = 2'd3} op_e;
    typedef enum logic [1:0] {K_LIN = 2'd0, K_MV = 2'd1, K_MVT = 2'd2} kind_e;

    localparam int ROM_W   = 16;
    localparam int BASE_W  = 8;
    localparam int DIM_W   = 4;
    localparam int NUM_ROM = 4;

    localparam int SEL_RDA = 0;
    localparam int SEL_RDB = 1;
    localparam int SEL_WR  = 2;
    localparam int SEL_OP  = 3;

    // Word returned by ROM "which" at instruction "idx"
    function automatic logic [ROM_W-1:0] prog_word(input int which, input int idx);
        logic [ROM_W-1:0] w;
        w = '0;
        case (which)
            SEL_RDA: case (idx)
                0: w = {6'd0, K_LIN, 8'd0};
                1: w = {6'd0, K_MV,  8'd16};
                2: w = {6'd0, K_MVT, 8'd16};
                3: w = {6'd0, K_LIN, 8'd30};
                default: w = '0;
            endcase
            SEL_RDB: case (idx)
                0: w = {4'd0, 4'd3, 8'd0};
                1: w = {4'd0, 4'd2, 8'd4};
                2: w = {4'd0, 4'd2, 8'd20};
                3: w = {4'd0, 4'd2, 8'd31};
                default: w = '0;
            endcase
            SEL_WR: case (idx)
                0: w = {3'd0, 1'b0, 4'd1, 8'd8};
                1: w = {3'd0, 1'b1, 4'd3, 8'd12};
                2: w = {3'd0, 1'b0, 4'd3, 8'd24};
                3: w = {3'd0, 1'b1, 4'd1, 8'd40};
                default: w = '0;
            endcase
            default: case (idx)
                0: w = {14'd0, OP_ADD};
                1: w = {14'd0, OP_MUL};
                2: w = {14'd0, OP_MUL};
                3: w = {14'd0, OP_DIV};
                default: w = '0;
            endcase
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pas_rom.sv
// Single-port instruction ROM: one slice of each pattern instruction.
// Assumes the contents come from pas_pkg::prog_word; the read is combinational.
module pas_rom #(
    parameter int WHICH  = 0,
    parameter int PC_W   = 2
) (
    input  logic [PC_W-1:0]              addr,
    output logic [pas_pkg::ROM_W-1:0]    data
);
    // Look up the slice for the addressed instruction
    always_comb data = pas_pkg::prog_word(WHICH, int'(addr));
endmodule

// File: rtl/pas_addr_gen.sv
// Expands the current pattern step (outer, inner) into read and write addresses.
// Assumes the problem offset is already computed; all sums wrap at ADDR_W.
module pas_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  pas_pkg::kind_e                 kind,
    input  logic [pas_pkg::BASE_W-1:0]     a_base,
    input  logic [pas_pkg::BASE_W-1:0]     b_base,
    input  logic [pas_pkg::BASE_W-1:0]     w_base,
    input  logic [pas_pkg::DIM_W-1:0]      ncols,
    input  logic [pas_pkg::DIM_W-1:0]      outer,
    input  logic [pas_pkg::DIM_W-1:0]      inner,
    input  logic [ADDR_W-1:0]              offset,
    output logic [ADDR_W-1:0]              rda,
    output logic [ADDR_W-1:0]              rdb,
    output logic [ADDR_W-1:0]              wra
);
    logic [ADDR_W-1:0] ab, bb, wb, ov, iv, cv;
    always_comb begin
        ab = ADDR_W'(a_base);
        bb = ADDR_W'(b_base);
        wb = ADDR_W'(w_base);
        ov = ADDR_W'(outer);
        iv = ADDR_W'(inner);
        cv = ADDR_W'(ncols);
    end

    // Pattern-dependent address arithmetic
    always_comb begin
        case (kind)
            pas_pkg::K_MV: begin
                rda = ab + ov * cv + iv + offset;
                rdb = bb + iv + offset;
            end
            pas_pkg::K_MVT: begin
                rda = ab + ov + iv * cv + offset;
                rdb = bb + iv + offset;
            end
            default: begin
                rda = ab + ov + offset;
                rdb = bb + ov + offset;
            end
        endcase
        wra = wb + ov + offset;
    end
endmodule

// File: rtl/pas_wr_delay.sv
// Write-address delay line: an entry inserted with latency L leaves L cycles later.
// Assumes issued entries never collide (the sequencer's idle slots ensure it).
module pas_wr_delay #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 27,
    localparam int LAT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_vld,
    input  logic [LAT_W-1:0]  ins_lat,
    input  logic              ins_sel,
    input  logic [ADDR_W-1:0] ins_addr,
    output logic              out_vld,
    output logic              out_sel,
    output logic [ADDR_W-1:0] out_addr
);
    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  sel_q;
    logic [ADDR_W-1:0] adr_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        localparam logic [LAT_W-1:0] SLOT = LAT_W'(i + 1);
        // Shift toward stage 0, or capture a new entry at its latency slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                sel_q[i] <= 1'b0;
                adr_q[i] <= '0;
            end else if (ins_vld && ins_lat == SLOT) begin
                vld_q[i] <= 1'b1;
                sel_q[i] <= ins_sel;
                adr_q[i] <= ins_addr;
            end else if (i == DEPTH - 1) begin
                vld_q[i] <= 1'b0;
                sel_q[i] <= 1'b0;
                adr_q[i] <= '0;
            end else begin
                vld_q[i] <= vld_q[(i + 1) % DEPTH];
                sel_q[i] <= sel_q[(i + 1) % DEPTH];
                adr_q[i] <= adr_q[(i + 1) % DEPTH];
            end
        end
    end

    assign out_vld  = vld_q[0];
    assign out_sel  = sel_q[0];
    assign out_addr = adr_q[0];
endmodule

// File: rtl/pattern_addr_seq.sv
// Pattern-instruction address sequencer for a two-RAM shared datapath.
// Steps a program of NINSTR pattern instructions, once for each of NPROB problems,
// offsetting problem p by p*PROB_STRIDE. Assumes LAT_DIV > LAT_ADD.
module pattern_addr_seq #(
    parameter int ADDR_W      = 8,
    parameter int NINSTR      = 4,
    parameter int NPROB       = 2,
    parameter int PROB_STRIDE = 64,
    parameter int LAT_ADD     = 12,
    parameter int LAT_DIV     = 27,
    localparam int PC_W       = (NINSTR > 1) ? $clog2(NINSTR) : 1,
    localparam int PROB_W     = (NPROB > 1) ? $clog2(NPROB) : 1,
    localparam int GAP        = LAT_DIV - LAT_ADD,
    localparam int GAP_W      = $clog2(GAP + 1),
    localparam int LAT_W      = $clog2(LAT_DIV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              op_vld,
    output logic [1:0]        op_sel,
    output logic [ADDR_W-1:0] rda_addr,
    output logic [ADDR_W-1:0] rdb_addr,
    output logic              wr_en,
    output logic              wr_sel,
    output logic [ADDR_W-1:0] wr_addr
);
    import pas_pkg::*;

    logic                running, fin;
    logic [PC_W-1:0]     pc;
    logic [PROB_W-1:0]   prob;
    logic [DIM_W-1:0]    o_idx, i_idx;
    logic [GAP_W-1:0]    gap;
    logic [ROM_W-1:0]    rom_q [NUM_ROM];

    // Four single-port ROMs share the program counter
    for (genvar r = 0; r < NUM_ROM; r++) begin : g_rom
        pas_rom #(.WHICH(r), .PC_W(PC_W)) i_rom (.addr(pc), .data(rom_q[r]));
    end

    kind_e             kind;
    op_e               op;
    logic [BASE_W-1:0] a_base, b_base, w_base;
    logic [DIM_W-1:0]  rows, cols, n_outer, n_inner;
    logic              w_ram;

    // Decode the instruction slices and the loop bounds
    always_comb begin
        kind    = kind_e'(rom_q[SEL_RDA][9:8]);
        a_base  = rom_q[SEL_RDA][7:0];
        rows    = rom_q[SEL_RDB][11:8];
        b_base  = rom_q[SEL_RDB][7:0];
        w_ram   = rom_q[SEL_WR][12];
        cols    = rom_q[SEL_WR][11:8];
        w_base  = rom_q[SEL_WR][7:0];
        op      = op_e'(rom_q[SEL_OP][1:0]);
        n_outer = (kind == K_MVT) ? cols : rows;
        n_inner = (kind == K_MVT) ? rows : ((kind == K_MV) ? cols : DIM_W'(1));
    end

    logic issue, last_in, instr_end, prog_end, all_end;
    always_comb begin
        issue     = running && !fin && (gap == '0);
        last_in   = (i_idx == n_inner - DIM_W'(1));
        instr_end = issue && last_in && (o_idx == n_outer - DIM_W'(1));
        prog_end  = instr_end && (pc == PC_W'(NINSTR - 1));
        all_end   = prog_end && (prob == PROB_W'(NPROB - 1));
    end

    // Run control: counters, idle-slot insertion and problem wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            fin     <= 1'b0;
            pc      <= '0;
            prob    <= '0;
            o_idx   <= '0;
            i_idx   <= '0;
            gap     <= '0;
        end else if (!running) begin
            if (start) begin
                running <= 1'b1;
                fin     <= 1'b0;
                pc      <= '0;
                prob    <= '0;
                o_idx   <= '0;
                i_idx   <= '0;
                gap     <= '0;
            end
        end else if (done) begin
            running <= 1'b0;
            fin     <= 1'b0;
        end else begin
            if (gap != '0) gap <= gap - GAP_W'(1);
            if (issue) begin
                if (op == OP_DIV) gap <= GAP_W'(GAP);
                if (instr_end) begin
                    o_idx <= '0;
                    i_idx <= '0;
                    pc    <= prog_end ? '0 : pc + PC_W'(1);
                    if (prog_end) prob <= all_end ? '0 : prob + PROB_W'(1);
                    if (all_end) fin <= 1'b1;
                end else if (last_in) begin
                    i_idx <= '0;
                    o_idx <= o_idx + DIM_W'(1);
                end else begin
                    i_idx <= i_idx + DIM_W'(1);
                end
            end
        end
    end

    logic [ADDR_W-1:0] offset, rda_c, rdb_c, wra_c;
    always_comb offset = ADDR_W'(prob) * ADDR_W'(PROB_STRIDE);

    pas_addr_gen #(.ADDR_W(ADDR_W)) i_agen (
        .kind(kind), .a_base(a_base), .b_base(b_base), .w_base(w_base),
        .ncols(cols), .outer(o_idx), .inner(i_idx), .offset(offset),
        .rda(rda_c), .rdb(rdb_c), .wra(wra_c)
    );

    logic [LAT_W-1:0] lat;
    always_comb lat = (op == OP_DIV) ? LAT_W'(LAT_DIV) : LAT_W'(LAT_ADD);

    pas_wr_delay #(.ADDR_W(ADDR_W), .DEPTH(LAT_DIV)) i_wdly (
        .clk(clk), .rst_n(rst_n),
        .ins_vld(issue && last_in), .ins_lat(lat), .ins_sel(w_ram), .ins_addr(wra_c),
        .out_vld(wr_en), .out_sel(wr_sel), .out_addr(wr_addr)
    );

    // Issue-side outputs
    always_comb begin
        busy     = running;
        done     = running && fin && (gap == '0);
        op_vld   = issue;
        op_sel   = issue ? op : OP_NONE;
        rda_addr = issue ? rda_c : '0;
        rdb_addr = issue ? rdb_c : '0;
    end
endmodule

// File: rtl/pas_checker.sv
// Checker for pattern_addr_seq: temporal rules on the run handshake and issue slots.
// Assumes it is bound to every instance of the sequencer.
module pas_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       op_vld,
    input logic [1:0] op_sel
);
    // R1: nothing is issued while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!op_vld && !done && op_sel == 2'd0));
    // R6: an issued slot never carries the "none" code
    a_r6_vld_has_op: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |-> (op_sel != 2'd0));
    // R6: a divide slot is followed by an idle slot
    a_r6_div_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_sel == 2'd3) |=> !op_vld);
    // R8: busy falls right after done
    a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R8: a run only begins after a start
    a_r8_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R9: a run is not cut short before done
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind pattern_addr_seq pas_checker i_pas_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .op_vld(op_vld), .op_sel(op_sel)
);

// File: tb/test_pattern_addr_seq.sv
`timescale 1ns/1ps
module test_pattern_addr_seq;
    localparam int AW = 8, NP = 2, STRIDE = 64, LADD = 12, LDIV = 27;
    localparam int GAPN = LDIV - LADD;
    localparam int NI = 4;
    // Program table: kind(0 lin,1 mv,2 mvt), abase, bbase, wbase, wsel, rows, cols, op
    localparam int PROG [NI][8] = '{
        '{0, 0,  0,  8,  0, 3, 1, 1},
        '{1, 16, 4,  12, 1, 2, 3, 2},
        '{2, 16, 20, 24, 0, 2, 3, 2},
        '{0, 30, 31, 40, 1, 2, 1, 3}
    };

    logic clk = 0, rst_n = 0, start = 0;
    logic busy, done, op_vld, wr_en, wr_sel;
    logic [1:0] op_sel;
    logic [AW-1:0] rda_addr, rdb_addr, wr_addr;

    pattern_addr_seq i_pattern_addr_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .op_vld(op_vld), .op_sel(op_sel), .rda_addr(rda_addr), .rdb_addr(rdb_addr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected issue and write lists
    int e_ni, e_nw, e_done;
    int e_it[64], e_op[64], e_a[64], e_b[64];
    int e_wt[64], e_ws[64], e_wa[64];
    // Captured lists
    bit cap_on = 0;
    int c_ni, c_nw, c_nd, c_done, c_idle_bad;
    int c_it[64], c_op[64], c_a[64], c_b[64];
    int c_wt[64], c_ws[64], c_wa[64];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Walk the table to build the expected slot and write lists
    task automatic build_expected();
        int t = 0;
        e_ni = 0; e_nw = 0;
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < NI; k++) begin
                int kd = PROG[k][0], r = PROG[k][5], c = PROG[k][6], op = PROG[k][7];
                int no = (kd == 2) ? c : r;
                int nin = (kd == 2) ? r : ((kd == 1) ? c : 1);
                for (int o = 0; o < no; o++) begin
                    for (int i = 0; i < nin; i++) begin
                        int a, b;
                        if (kd == 1) begin a = PROG[k][1] + o*c + i; b = PROG[k][2] + i; end
                        else if (kd == 2) begin a = PROG[k][1] + o + i*c; b = PROG[k][2] + i; end
                        else begin a = PROG[k][1] + o; b = PROG[k][2] + o; end
                        e_it[e_ni] = t; e_op[e_ni] = op;
                        e_a[e_ni] = (a + p*STRIDE) % 256; e_b[e_ni] = (b + p*STRIDE) % 256;
                        e_ni++;
                        if (i == nin - 1) begin
                            e_wt[e_nw] = t + ((op == 3) ? LDIV : LADD);
                            e_ws[e_nw] = PROG[k][4];
                            e_wa[e_nw] = (PROG[k][3] + o + p*STRIDE) % 256;
                            e_nw++;
                        end
                        t += 1 + ((op == 3) ? GAPN : 0);
                    end
                end
            end
        end
        e_done = t;
    endtask

    // Capture outputs away from the clock edge
    always @(negedge clk) if (cap_on) begin
        if (op_vld) begin
            c_it[c_ni] = cyc; c_op[c_ni] = op_sel; c_a[c_ni] = rda_addr; c_b[c_ni] = rdb_addr;
            if (c_ni < 63) c_ni++;
        end else if (busy && op_sel != 0) c_idle_bad++;
        if (wr_en) begin
            c_wt[c_nw] = cyc; c_ws[c_nw] = wr_sel; c_wa[c_nw] = wr_addr;
            if (c_nw < 63) c_nw++;
        end
        if (done) begin c_done = cyc; c_nd++; end
    end

    task automatic run_and_check(input bit stray_start);
        int s_cyc, t0;
        c_ni = 0; c_nw = 0; c_nd = 0; c_done = -1; c_idle_bad = 0;
        cap_on = 1;
        @(negedge clk); start = 1; s_cyc = cyc;
        @(negedge clk); start = 0;
        check(busy == 1, "R8 busy after start", busy, 1);
        if (stray_start) begin
            repeat (10) @(negedge clk);
            start = 1; @(negedge clk); start = 0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check(busy == 0, "R8 busy low after done", busy, 0);
        repeat (LDIV + 4) @(negedge clk);
        cap_on = 0;
        t0 = c_it[0];
        check(t0 == s_cyc + 1, "R8 first slot timing", t0 - s_cyc, 1);
        check(c_ni == e_ni, "R7 slot count", c_ni, e_ni);
        check(c_nw == e_nw, "R5 write count", c_nw, e_nw);
        check(c_nd == 1, "R9 single done", c_nd, 1);
        check(c_done - t0 == e_done, "R8 done timing", c_done - t0, e_done);
        check(c_idle_bad == 0, "R6 idle slot op code", c_idle_bad, 0);
        for (int n = 0; n < e_ni && n < c_ni; n++) begin
            string rq;
            rq = (n < 3 || (n >= 17 && n < 20)) ? "R2" : ((n % 17) < 9 ? "R3" : ((n % 17) < 15 ? "R4" : "R2"));
            check(c_it[n] - t0 == e_it[n], "R6/R7 slot cycle", c_it[n] - t0, e_it[n]);
            check(c_op[n] == e_op[n], "R6 op code", c_op[n], e_op[n]);
            check(c_a[n] == e_a[n], {rq, " read A addr (R7 offset)"}, c_a[n], e_a[n]);
            check(c_b[n] == e_b[n], {rq, " read B addr (R7 offset)"}, c_b[n], e_b[n]);
        end
        for (int n = 0; n < e_nw && n < c_nw; n++) begin
            check(c_wt[n] - t0 == e_wt[n], "R5 write cycle", c_wt[n] - t0, e_wt[n]);
            check(c_ws[n] == e_ws[n], "R5 write RAM", c_ws[n], e_ws[n]);
            check(c_wa[n] == e_wa[n], "R5 write addr", c_wa[n], e_wa[n]);
        end
    endtask

    initial begin
        build_expected();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset and idle state
        check(busy == 0 && done == 0, "R1 idle handshake", {busy, done}, 0);
        check(op_vld == 0 && op_sel == 0, "R1 idle op", {op_vld, op_sel}, 0);
        check(wr_en == 0, "R1 idle write", wr_en, 0);
        run_and_check(0);
        // R9 with stray start; R8 restart from problem 0
        run_and_check(1);
        check(busy == 0 && op_vld == 0, "R1 idle after runs", {busy, op_vld}, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule